// File: doc/BRIEF.md
# Buffer Map Entry Fetch Unit

This unit keeps the base address and per-buffer map size of a buffer map table held in packet memory. It also walks that table for one buffer at a time. When software writes the base register, the unit adds the packet-memory real base and the packet-memory offset to the address before it stores it. A lookup can then use the stored value with no further addition. When software reads the register back, the same sum is subtracted, so software sees the address it wrote. The two adjusting values come from registers outside the unit and arrive as input ports.

A start strobe carries a buffer number. On a start, the unit computes the address of that buffer's first 8-byte map word. It then issues one memory read request per word over a valid/ready handshake, with only one request outstanding at a time. Each 64-bit response is stored in an output slot in arrival order. When the last word is in, the unit pulses done together with the word count. A 64-byte map is fetched as five words, and its last three words are never read.

Top module: `bufmap_addr_unit`

## Requirements
- R1: A write stores base = (written value with bits 5:0 cleared) + realBase + memOffset, taking both adjusters as they are at the write edge. Every later lookup starts from this stored base.
- R2: A read returns the written bits 31:6 and the written size bits 1:0. Bits 5:2 always read as zero, whatever was written. The read value is stored base − realBase − memOffset, with bits 5:0 cleared before the size bits are inserted.
- R3: After reset, the base used by lookups is 0x0020_0000 and the size code is 00.
- R4: The size code in bits 1:0 selects bytes per buffer and words fetched: 00 gives 8 bytes and 1 word, 01 gives 16 and 2, 10 gives 32 and 4, 11 gives 64 and 5.
- R5: The first request address is stored base + bufNum × bytes-per-buffer, modulo 2^32. Each following request adds 8.
- R6: memReqValid stays high with a stable memReqAddr until memReqReady is seen. No new request is raised until the response to the previous one has arrived.
- R7: The i-th response word (i counted from 0) appears in bits [64i+63:64i] of entriesOut. done is high for exactly one cycle, in the cycle after the last response, and doneCount then shows the word count.
- R8: busy rises in the cycle after an accepted start and falls in the same cycle that done is high. A start that arrives while busy is high has no effect on addresses or data.
- R9: Changing realBase or memOffset after a write does not change the stored base that lookups use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Base register write strobe |
| cfgWrData | input | 32 | Value to write: bits 31:6 address, bits 1:0 size code |
| cfgRdData | output | 32 | Read-back value of the base register |
| realBase | input | 32 | Packet-memory real base used for adjustment |
| memOffset | input | 32 | Packet-memory offset used for adjustment |
| startValid | input | 1 | Start strobe for a fetch |
| bufNum | input | BUF_W | Buffer number to fetch |
| busy | output | 1 | A fetch is in progress |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memReqAddr | output | 32 | Read request address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| doneCount | output | 3 | Number of words fetched |
| entriesOut | output | 320 | Captured words, slot 0 in the low bits |

## Verification
The bench sweeps all four size codes across buffer numbers 0, 1, 5 and the largest one, under two different pairs of adjusters. This separates a wrong shift per size and a wrong word count. It also catches an adjustment that drops one of the two adjusting terms. The request-ready delay changes from word to word, which exposes requests that do not hold their address while waiting. Further cases cover read-back of values with the reserved bits set, the base used out of reset, a start raised in the middle of a fetch, and an adjuster changed after a write.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int MAX_WORDS = 5;
  localparam int WORD_W = 64;

  typedef struct packed {
    logic load;     // latch first address and word count
    logic capture;  // store response word, step address
  } bam_strb_s;

  function automatic logic [2:0] wordsForSize(input logic [1:0] sz);
    case (sz)
      2'd0: return 3'd1;
      2'd1: return 3'd2;
      2'd2: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/bam_datapath.sv
module bam_datapath
  import bam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUF_W = 8,
  parameter logic [ADDR_W-1:0] RST_BASE = 32'h0020_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgWrData,
  output logic [ADDR_W-1:0]         cfgRdData,
  input  logic [ADDR_W-1:0]         realBase,
  input  logic [ADDR_W-1:0]         memOffset,
  input  logic [BUF_W-1:0]          bufNum,
  input  bam_strb_s                 strb,
  output logic                      lastWord,
  output logic [ADDR_W-1:0]         entryAddr,
  output logic [2:0]                entryCount,
  output logic [MAX_WORDS*WORD_W-1:0] entriesOut,
  input  logic [WORD_W-1:0]         rspData
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(63);

  logic [ADDR_W-1:0] adjBase;
  logic [1:0]        mapSize;
  logic [2:0]        wordIdx;
  logic [WORD_W-1:0] words [MAX_WORDS];
  logic [ADDR_W-1:0] firstAddr;
  logic [ADDR_W-1:0] undone;

  assign firstAddr = adjBase + (ADDR_W'(bufNum) << (3 + mapSize));
  assign undone    = adjBase - realBase - memOffset;
  assign cfgRdData = (undone & ALIGN_MASK) | ADDR_W'(mapSize);
  assign lastWord  = (wordIdx == entryCount - 3'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adjBase <= RST_BASE;
      mapSize <= 2'd0;
    end else if (cfgWrEn) begin
      adjBase <= (cfgWrData & ALIGN_MASK) + realBase + memOffset;
      mapSize <= cfgWrData[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddr  <= '0;
      entryCount <= 3'd1;
      wordIdx    <= '0;
    end else if (strb.load) begin
      entryAddr  <= firstAddr;
      entryCount <= wordsForSize(mapSize);
      wordIdx    <= '0;
    end else if (strb.capture) begin
      entryAddr <= entryAddr + ADDR_W'(8);
      wordIdx   <= wordIdx + 3'd1;
    end
  end

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) words[i] <= '0;
      else if (strb.capture && wordIdx == 3'(i)) words[i] <= rspData;
    end
    assign entriesOut[i*WORD_W +: WORD_W] = words[i];
  end
endmodule

// File: rtl/bam_control.sv
module bam_control
  import bam_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      memReqReady,
  input  logic      memRspValid,
  input  logic      lastWord,
  output bam_strb_s strb,
  output logic      memReqValid,
  output logic      busy,
  output logic      done
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;
  state_e state, stateNext;

  always_comb begin
    strb = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (startValid) begin
        strb.load = 1'b1;
        stateNext = S_REQ;
      end
      S_REQ: if (memReqReady) stateNext = S_WAIT;
      S_WAIT: if (memRspValid) begin
        strb.capture = 1'b1;
        stateNext = lastWord ? S_IDLE : S_REQ;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == S_WAIT) && memRspValid && lastWord;
    end
  end

  assign memReqValid = (state == S_REQ);
  assign busy = (state != S_IDLE);
endmodule

// File: rtl/bufmap_addr_unit.sv
module bufmap_addr_unit
  import bam_pkg::*;
#(
  parameter int BUF_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [31:0]                  cfgWrData,
  output logic [31:0]                  cfgRdData,
  input  logic [31:0]                  realBase,
  input  logic [31:0]                  memOffset,
  input  logic                         startValid,
  input  logic [BUF_W-1:0]             bufNum,
  output logic                         busy,
  output logic                         memReqValid,
  input  logic                         memReqReady,
  output logic [31:0]                  memReqAddr,
  input  logic                         memRspValid,
  input  logic [63:0]                  memRspData,
  output logic                         done,
  output logic [2:0]                   doneCount,
  output logic [MAX_WORDS*WORD_W-1:0]  entriesOut
);
  bam_strb_s strb;
  logic lastWord;

  bam_control u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .lastWord(lastWord), .strb(strb), .memReqValid(memReqValid),
    .busy(busy), .done(done)
  );

  bam_datapath #(.ADDR_W(32), .BUF_W(BUF_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .realBase(realBase), .memOffset(memOffset),
    .bufNum(bufNum), .strb(strb), .lastWord(lastWord),
    .entryAddr(memReqAddr), .entryCount(doneCount),
    .entriesOut(entriesOut), .rspData(memRspData)
  );
endmodule

// File: rtl/bam_checker.sv
module bam_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memReqAddr,
  input logic        done,
  input logic [2:0]  doneCount,
  input logic [31:0] cfgRdData
);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);
  a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r4_count_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (doneCount == 3'd1 || doneCount == 3'd2 || doneCount == 3'd4 || doneCount == 3'd5));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[5:2] == 4'd0);
endmodule

bind bufmap_addr_unit bam_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .done(done),
  .doneCount(doneCount), .cfgRdData(cfgRdData)
);

// File: tb/bufmap_addr_unit_tb.sv
module bufmap_addr_unit_tb;
  localparam int BUF_W = 8;
  logic clk = 0, rstN = 0;
  logic cfgWrEn = 0;
  logic [31:0] cfgWrData = 0, realBase = 32'h0020_0000, memOffset = 0;
  logic startValid = 0, memReqReady = 0, memRspValid = 0;
  logic [BUF_W-1:0] bufNum = 0;
  logic [63:0] memRspData = 0;
  logic [31:0] cfgRdData, memReqAddr;
  logic busy, memReqValid, done;
  logic [2:0] doneCount;
  logic [319:0] entriesOut;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  bufmap_addr_unit #(.BUF_W(BUF_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] memWord(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  task automatic writeBase(input logic [31:0] v);
    @(negedge clk); cfgWrData = v; cfgWrEn = 1;
    @(negedge clk); cfgWrEn = 0;
  endtask

  // base: expected stored base; sz: size code
  task automatic fetch(input logic [31:0] base, input int sz, input int b, input bit poke);
    int n;
    logic [31:0] a;
    n = (sz == 3) ? 5 : (1 << sz);
    @(negedge clk); startValid = 1; bufNum = BUF_W'(b);
    @(negedge clk); startValid = 0;
    chk(busy == 1, "R8 busy after start", 64'(busy), 1);
    for (int e = 0; e < n; e++) begin
      a = base + 32'(b * (8 << sz)) + 32'(8 * e);
      for (int d = 0; d < (e % 3); d++) begin
        chk(memReqValid == 1 && memReqAddr == a, "R6 request held", 64'(memReqAddr), 64'(a));
        if (poke && e == 2) begin startValid = 1; bufNum = BUF_W'(b + 3); end
        @(negedge clk); startValid = 0;
      end
      memReqReady = 1;
      chk(memReqValid == 1 && memReqAddr == a, "R5 request address", 64'(memReqAddr), 64'(a));
      @(negedge clk); memReqReady = 0;
      chk(memReqValid == 0, "R6 one outstanding", 64'(memReqValid), 0);
      memRspValid = 1; memRspData = memWord(a);
      @(negedge clk); memRspValid = 0;
      if (e < n - 1) chk(done == 0, "R7 no early done", 64'(done), 0);
    end
    chk(done == 1 && busy == 0, "R8 done with busy low", {done, busy}, 2'b10);
    chk(doneCount == 3'(n), "R4 word count", 64'(doneCount), 64'(n));
    for (int e = 0; e < n; e++) begin
      a = base + 32'(b * (8 << sz)) + 32'(8 * e);
      chk(entriesOut[e*64 +: 64] == memWord(a), "R7 captured word", entriesOut[e*64 +: 64], memWord(a));
    end
    @(negedge clk);
    chk(done == 0, "R7 done single pulse", 64'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, exp;
    repeat (3) @(negedge clk); rstN = 1;
    chk(busy == 0 && done == 0 && memReqValid == 0, "R3 idle after reset", {busy, done, memReqValid}, 0);
    chk(cfgRdData == 32'h0, "R3 read-back after reset", 64'(cfgRdData), 0);
    fetch(32'h0020_0000, 0, 3, 0); // R3 reset base, 8-byte map
    // R2 read-back with reserved and low bits set
    realBase = 32'h0011_2240; memOffset = 32'h0000_0C80;
    for (int k = 0; k < 4; k++) begin
      v = 32'h1234_56FC ^ (32'(k) << 20) | 32'(k);
      writeBase(v);
      exp = (v & 32'hFFFF_FFC0) | 32'(k);
      chk(cfgRdData == exp, "R2 read-back", 64'(cfgRdData), 64'(exp));
    end
    // R1 R4 R5 sweep under two adjuster pairs
    for (int p = 0; p < 2; p++) begin
      realBase  = p ? 32'hF000_0000 : 32'h0020_0000;
      memOffset = p ? 32'h1800_0040 : 32'h0000_1000;
      for (int sz = 0; sz < 4; sz++) begin
        v = 32'h0004_0000 + (32'(sz) << 6) | 32'(sz);
        writeBase(v);
        exp = (v & 32'hFFFF_FFC0) + realBase + memOffset;
        foreach (bufNumList[i]) fetch(exp, sz, bufNumList[i], 0);
      end
    end
    // R8 start while busy ignored
    fetch(exp, 3, 7, 1);
    // R9 adjuster change after write leaves base unchanged
    realBase = 32'h0000_0400; memOffset = 32'h0;
    fetch(exp, 3, 2, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int bufNumList [4] = '{0, 1, 5, 255};
endmodule